// File: doc/BRIEF.md
# Timer Interrupt Router

This block sits between a bank of timer channels and the interrupt fabric. Each channel raises a fire event when its comparator matches, and the router turns that event into one of three results: a level request held on an interrupt line and recorded in a status register, a one-cycle pulse on a line, or a 32-bit memory-write message handed to a bus master. Which line a channel drives comes from its route field. When legacy replacement mode is on, channel 0 and channel 1 are instead forced onto fixed lines, and the two legacy sources are cut off from those lines.

Those two legacy sources are a periodic-timer input and a real-time-clock input. Outside legacy mode they pass through to line 0 and line 8. The legacy-timer enable output tells the legacy timer whether it still owns its line. The status register is write-one-to-clear and only records level-mode requests. Message requests are queued per channel and are served one at a time, lowest channel first. A request is held until it is acknowledged.

Top module: `irq_router`

## Requirements
- R1: With legacy mode on, channel 0 drives line 0 and channel 1 drives line 8, whatever their route fields hold. All other channels, and all channels with legacy mode off, drive the line whose index is their route field.
- R2: A level-mode fire on an enabled channel with messaging off sets that channel's status bit and holds its line high until the request is cleared.
- R3: An edge-mode fire on an enabled channel with messaging off drives its line high for exactly one cycle and leaves its status bit clear.
- R4: A fire on an enabled channel with messaging on drives no line and leaves the status bit unchanged. It raises msg_req_o with msg_addr_o set to bits 63:32 and msg_data_o set to bits 31:0 of that channel's 64-bit message word. The request and its address and data stay unchanged until msg_ack_i is seen high on a clock edge.
- R5: clear_i, or a fire while the channel enable or the global enable is low, clears the channel's status bit and drops its line. A channel with messaging on never drives a line.
- R6: A status write clears each status bit written as 1. Bits written as 0 leave their status bits unchanged.
- R7: One cycle after legacy_i goes high, leg_tmr_en_o is low, and leg_tmr_i and rtc_i no longer reach lines 0 and 8.
- R8: With legacy mode off, line 0 follows leg_tmr_i and line 8 follows rtc_i, one cycle late. After leaving legacy mode, line 8 shows the level rtc_i had last, including changes made during legacy mode. After reset, leg_tmr_en_o is high and all lines, status bits and message requests are low.
- R9: A 0-to-1 change of a channel's message enable clears that channel's status bit.
- R10: Message fires that are pending together are issued one request at a time, lowest channel index first. Each request is issued one cycle after the previous one is acknowledged.
- R11: In the same cycle, a fire that sets a status bit wins over a status write that clears it, and clear_i wins over a fire.
- R12: All state changes caused by inputs sampled on a clock edge show at the outputs right after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| fire_i | input | N_CHAN | Per-channel fire event |
| clear_i | input | N_CHAN | Per-channel request clear |
| chan_en_i | input | N_CHAN | Per-channel enable |
| level_i | input | N_CHAN | 1 = level mode, 0 = edge mode |
| msg_en_i | input | N_CHAN | Per-channel message routing enable |
| route_i | input | N_CHAN*ROUTE_W | Per-channel line index, channel c at bits c*ROUTE_W |
| msg_word_i | input | N_CHAN*64 | Per-channel message word, address in bits 63:32, data in bits 31:0 |
| glb_en_i | input | 1 | Global enable |
| legacy_i | input | 1 | Legacy replacement mode |
| leg_tmr_i | input | 1 | Legacy periodic-timer interrupt input |
| rtc_i | input | 1 | Real-time-clock interrupt input |
| sts_wr_i | input | 1 | Status register write strobe |
| sts_wdata_i | input | N_CHAN | Status write data, one bit per channel |
| msg_ack_i | input | 1 | Message write accepted |
| irq_o | output | N_LINES | Interrupt lines |
| leg_tmr_en_o | output | 1 | Legacy timer owns its line |
| status_o | output | N_CHAN | Status register |
| msg_req_o | output | 1 | Message write request |
| msg_addr_o | output | 32 | Message address |
| msg_data_o | output | 32 | Message data |

## Verification
The router must resolve events that reach the same channel's status bit in one cycle. A fire that sets the bit can arrive together with a status write that clears it, or together with clear_i. The bench drives both pairs on one edge and checks the status bit right after that edge, expecting the bit set for fire with write and cleared for fire with clear_i. A second coincidence, two message fires on one edge, is judged by the order and contents of the requests and by whether each request holds until its acknowledge.

// File: rtl/irq_rtr_pkg.sv
`timescale 1ns/1ps
package irq_rtr_pkg;
  localparam int MSG_W = 64;

  typedef struct packed {
    logic [31:0] addr;
    logic [31:0] data;
  } msg_word_t;

  typedef enum logic [2:0] {
    ACT_IDLE,
    ACT_DROP,
    ACT_LEVEL,
    ACT_EDGE,
    ACT_MSG
  } chan_act_e;
endpackage

// File: rtl/irq_chan_ctl.sv
`timescale 1ns/1ps
module irq_chan_ctl
  import irq_rtr_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic fire_i,
  input  logic clear_i,
  input  logic chan_en_i,
  input  logic glb_en_i,
  input  logic level_i,
  input  logic msg_en_i,
  input  logic sts_clr_i,
  input  logic ack_clr_i,
  output logic sts_o,
  output logic pulse_o,
  output logic pend_o
);
  chan_act_e act;
  logic sts_q, pulse_q, pend_q, msg_en_q;
  logic msg_rise, sts_keep;

  assign msg_rise = msg_en_i & ~msg_en_q;
  assign sts_keep = sts_q & ~(sts_clr_i | msg_rise);

  always_comb begin
    if (clear_i)                             act = ACT_DROP;
    else if (fire_i && !(chan_en_i && glb_en_i)) act = ACT_DROP;
    else if (fire_i && msg_en_i)             act = ACT_MSG;
    else if (fire_i && level_i)              act = ACT_LEVEL;
    else if (fire_i)                         act = ACT_EDGE;
    else                                     act = ACT_IDLE;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sts_q    <= 1'b0;
      pulse_q  <= 1'b0;
      pend_q   <= 1'b0;
      msg_en_q <= 1'b0;
    end else begin
      msg_en_q <= msg_en_i;
      pulse_q  <= (act == ACT_EDGE);
      unique case (act)
        ACT_DROP, ACT_EDGE: sts_q <= 1'b0;
        ACT_LEVEL:          sts_q <= 1'b1;
        default:            sts_q <= sts_keep;
      endcase
      if (act == ACT_MSG)  pend_q <= 1'b1;
      else if (ack_clr_i)  pend_q <= 1'b0;
    end
  end

  assign sts_o   = sts_q;
  assign pulse_o = pulse_q;
  assign pend_o  = pend_q;

  // R2 / R11: enabled level fire sets status even against a status write
  a_r2_level_sets: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fire_i && !clear_i && chan_en_i && glb_en_i && !msg_en_i && level_i |=> sts_o);
  // R3: edge fire gives a pulse and no status
  a_r3_edge_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fire_i && !clear_i && chan_en_i && glb_en_i && !msg_en_i && !level_i |=> pulse_o && !sts_o);
  // R3: a pulse only follows a fire
  a_r3_pulse_src: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pulse_o |-> $past(fire_i));
  // R5: clear wins
  a_r5_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear_i |=> !sts_o && !pulse_o);
  // R9: message-enable rise clears status
  a_r9_msg_rise: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(msg_en_i) |=> !sts_o);
endmodule

// File: rtl/irq_line_mux.sv
`timescale 1ns/1ps
module irq_line_mux #(
  parameter int N_CHAN   = 4,
  parameter int N_LINES  = 16,
  parameter int ROUTE_W  = 4,
  parameter int TMR_LINE = 0,
  parameter int RTC_LINE = 8
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic [N_CHAN*ROUTE_W-1:0]   route_i,
  input  logic [N_CHAN-1:0]           drive_i,
  input  logic                        legacy_i,
  input  logic                        tmr_i,
  input  logic                        rtc_i,
  output logic [N_LINES-1:0]          irq_o
);
  always_comb begin
    irq_o = '0;
    for (int c = 0; c < N_CHAN; c++) begin
      int eff;
      if (legacy_i && c == 0)      eff = TMR_LINE;
      else if (legacy_i && c == 1) eff = RTC_LINE;
      else                         eff = int'(route_i[c*ROUTE_W +: ROUTE_W]);
      if (drive_i[c] && eff < N_LINES) irq_o[eff] = 1'b1;
    end
    if (!legacy_i) begin
      irq_o[TMR_LINE] = irq_o[TMR_LINE] | tmr_i;
      irq_o[RTC_LINE] = irq_o[RTC_LINE] | rtc_i;
    end
  end

  // R1: forced legacy lines
  a_r1_leg_ch0: assert property (@(posedge clk_i) disable iff (!rst_ni)
    legacy_i && drive_i[0] |-> irq_o[TMR_LINE]);
  a_r1_leg_ch1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    legacy_i && drive_i[1] |-> irq_o[RTC_LINE]);
endmodule

// File: rtl/irq_msg_arb.sv
`timescale 1ns/1ps
module irq_msg_arb
  import irq_rtr_pkg::*;
#(
  parameter int N_CHAN = 4,
  localparam int SEL_W = (N_CHAN > 1) ? $clog2(N_CHAN) : 1
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic [N_CHAN-1:0]         pend_i,
  input  logic [N_CHAN*MSG_W-1:0]   words_i,
  input  logic                      ack_i,
  output logic                      req_o,
  output logic [31:0]               addr_o,
  output logic [31:0]               data_o,
  output logic [N_CHAN-1:0]         ack_clr_o
);
  logic             req_q;
  logic [SEL_W-1:0] sel_q, pick;
  logic [31:0]      addr_q, data_q;
  msg_word_t        w;

  always_comb begin
    pick = '0;
    for (int c = N_CHAN - 1; c >= 0; c--) begin
      if (pend_i[c]) pick = SEL_W'(c);
    end
    w = words_i[int'(pick)*MSG_W +: MSG_W];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      req_q  <= 1'b0;
      sel_q  <= '0;
      addr_q <= '0;
      data_q <= '0;
    end else if (!req_q && |pend_i) begin
      req_q  <= 1'b1;
      sel_q  <= pick;
      addr_q <= w.addr;
      data_q <= w.data;
    end else if (req_q && ack_i) begin
      req_q <= 1'b0;
    end
  end

  always_comb begin
    ack_clr_o = '0;
    if (req_q && ack_i) ack_clr_o[sel_q] = 1'b1;
  end

  assign req_o  = req_q;
  assign addr_o = addr_q;
  assign data_o = data_q;

  // R4: request holds until acknowledged
  a_r4_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_o && !ack_i |=> req_o && $stable(addr_o) && $stable(data_o));
  // R10: one request at a time, dropped after acknowledge
  a_r10_ack_drop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_o && ack_i |=> !req_o);
endmodule

// File: rtl/irq_router.sv
`timescale 1ns/1ps
module irq_router
  import irq_rtr_pkg::*;
#(
  parameter int N_CHAN   = 4,
  parameter int N_LINES  = 16,
  parameter int TMR_LINE = 0,
  parameter int RTC_LINE = 8,
  localparam int ROUTE_W = $clog2(N_LINES)
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic [N_CHAN-1:0]          fire_i,
  input  logic [N_CHAN-1:0]          clear_i,
  input  logic [N_CHAN-1:0]          chan_en_i,
  input  logic [N_CHAN-1:0]          level_i,
  input  logic [N_CHAN-1:0]          msg_en_i,
  input  logic [N_CHAN*ROUTE_W-1:0]  route_i,
  input  logic [N_CHAN*MSG_W-1:0]    msg_word_i,
  input  logic                       glb_en_i,
  input  logic                       legacy_i,
  input  logic                       leg_tmr_i,
  input  logic                       rtc_i,
  input  logic                       sts_wr_i,
  input  logic [N_CHAN-1:0]          sts_wdata_i,
  input  logic                       msg_ack_i,
  output logic [N_LINES-1:0]         irq_o,
  output logic                       leg_tmr_en_o,
  output logic [N_CHAN-1:0]          status_o,
  output logic                       msg_req_o,
  output logic [31:0]                msg_addr_o,
  output logic [31:0]                msg_data_o
);
  logic              leg_q, tmr_q, rtc_q;
  logic [N_CHAN-1:0] sts, pulse, pend, ack_clr, drive;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      leg_q <= 1'b0;
      tmr_q <= 1'b0;
      rtc_q <= 1'b0;
    end else begin
      leg_q <= legacy_i;
      tmr_q <= leg_tmr_i;
      rtc_q <= rtc_i;   // recorded in every mode
    end
  end

  for (genvar c = 0; c < N_CHAN; c++) begin : g_chan
    irq_chan_ctl u_chan (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .fire_i    (fire_i[c]),
      .clear_i   (clear_i[c]),
      .chan_en_i (chan_en_i[c]),
      .glb_en_i  (glb_en_i),
      .level_i   (level_i[c]),
      .msg_en_i  (msg_en_i[c]),
      .sts_clr_i (sts_wr_i & sts_wdata_i[c]),
      .ack_clr_i (ack_clr[c]),
      .sts_o     (sts[c]),
      .pulse_o   (pulse[c]),
      .pend_o    (pend[c])
    );
    assign drive[c] = (sts[c] | pulse[c]) & ~msg_en_i[c];
  end

  irq_line_mux #(
    .N_CHAN   (N_CHAN),
    .N_LINES  (N_LINES),
    .ROUTE_W  (ROUTE_W),
    .TMR_LINE (TMR_LINE),
    .RTC_LINE (RTC_LINE)
  ) u_mux (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .route_i  (route_i),
    .drive_i  (drive),
    .legacy_i (leg_q),
    .tmr_i    (tmr_q),
    .rtc_i    (rtc_q),
    .irq_o    (irq_o)
  );

  irq_msg_arb #(.N_CHAN(N_CHAN)) u_arb (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .pend_i    (pend),
    .words_i   (msg_word_i),
    .ack_i     (msg_ack_i),
    .req_o     (msg_req_o),
    .addr_o    (msg_addr_o),
    .data_o    (msg_data_o),
    .ack_clr_o (ack_clr)
  );

  assign leg_tmr_en_o = ~leg_q;
  assign status_o     = sts;

  // R7: legacy entry releases the legacy timer
  a_r7_leg_en: assert property (@(posedge clk_i) disable iff (!rst_ni)
    legacy_i |=> !leg_tmr_en_o);
  // R8: passthrough of the legacy timer outside legacy mode
  a_r8_tmr_pass: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !legacy_i && leg_tmr_i |=> irq_o[TMR_LINE]);
  // R6: zero bits in a status write never clear on their own
  a_r6_w1c: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sts_wr_i && !sts_wdata_i[0] && status_o[0] && !clear_i[0] && !fire_i[0]
      && !$rose(msg_en_i[0]) |=> status_o[0]);
endmodule

// File: tb/irq_router_bench.sv
`timescale 1ns/1ps
module irq_router_bench;
  localparam int NC = 4;
  localparam int NL = 16;
  localparam int RW = 4;

  logic            clk_i = 1'b0;
  logic            rst_ni = 1'b0;
  logic [NC-1:0]   fire_i = '0, clear_i = '0, chan_en_i = '1, level_i = '1, msg_en_i = '0;
  logic [NC*RW-1:0] route_i = '0;
  logic [NC*64-1:0] msg_word_i = '0;
  logic            glb_en_i = 1'b1, legacy_i = 1'b0, leg_tmr_i = 1'b0, rtc_i = 1'b0;
  logic            sts_wr_i = 1'b0, msg_ack_i = 1'b0;
  logic [NC-1:0]   sts_wdata_i = '0;
  logic [NL-1:0]   irq_o;
  logic            leg_tmr_en_o, msg_req_o;
  logic [NC-1:0]   status_o;
  logic [31:0]     msg_addr_o, msg_data_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #4 clk_i = ~clk_i;

  irq_router #(.N_CHAN(NC), .N_LINES(NL)) u_irq_router (.*);

  // {chan[1:0], route[3:0], legacy, expected line[3:0]}
  localparam logic [10:0] VEC [6] = '{
    {2'd0, 4'd5,  1'b0, 4'd5},
    {2'd0, 4'd5,  1'b1, 4'd0},
    {2'd1, 4'd3,  1'b1, 4'd8},
    {2'd1, 4'd3,  1'b0, 4'd3},
    {2'd2, 4'd12, 1'b1, 4'd12},
    {2'd3, 4'd8,  1'b0, 4'd8}
  };

  task automatic step();
    @(posedge clk_i);
    @(negedge clk_i);
  endtask

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic clr_sts(input logic [NC-1:0] bits);
    sts_wr_i = 1'b1; sts_wdata_i = bits;
    step();
    sts_wr_i = 1'b0; sts_wdata_i = '0;
  endtask

  initial begin
    #(8 * 50000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    step();
    // R8 reset state
    chk("R8 reset lines", 64'(irq_o), 64'h0);
    chk("R8 reset leg_en", 64'(leg_tmr_en_o), 64'h1);
    chk("R8 reset status", 64'(status_o), 64'h0);
    chk("R8 reset msg_req", 64'(msg_req_o), 64'h0);

    // R1 / R2 / R6 routing table
    foreach (VEC[k]) begin
      automatic int ch = int'(VEC[k][10:9]);
      automatic logic [NL-1:0] exp_l = NL'(1) << VEC[k][3:0];
      route_i[ch*RW +: RW] = VEC[k][8:5];
      legacy_i = VEC[k][4];
      level_i = '1;
      step();
      fire_i[ch] = 1'b1;
      step();
      fire_i[ch] = 1'b0;
      chk("R1 route", 64'(irq_o), 64'(exp_l));
      chk("R2 status set", 64'(status_o), 64'(NC'(1) << ch));
      step(); step();
      chk("R2 line held", 64'(irq_o), 64'(exp_l));
      clr_sts(NC'(1) << ch);
      chk("R6 w1c status", 64'(status_o), 64'h0);
      chk("R6 w1c line", 64'(irq_o), 64'h0);
    end
    legacy_i = 1'b0;
    step();

    // R3 edge pulse
    route_i[2*RW +: RW] = 4'd4;
    level_i[2] = 1'b0;
    fire_i[2] = 1'b1;
    step();
    fire_i[2] = 1'b0;
    chk("R3 pulse high", 64'(irq_o), 64'h10);
    chk("R3 no status", 64'(status_o), 64'h0);
    step();
    chk("R3 pulse one cycle", 64'(irq_o), 64'h0);
    level_i[2] = 1'b1;

    // R6 zero bits keep their status
    route_i[3*RW +: RW] = 4'd6;
    fire_i = 4'b1100;
    step();
    fire_i = '0;
    clr_sts(4'b1000);
    chk("R6 only written bit cleared", 64'(status_o), 64'h4);
    clr_sts(4'b0000);
    chk("R6 zero write no effect", 64'(status_o), 64'h4);
    chk("R6 line kept", 64'(irq_o), 64'h10);

    // R5 clear_i, channel disable, global disable
    clear_i[2] = 1'b1;
    step();
    clear_i[2] = 1'b0;
    chk("R5 clear status", 64'(status_o), 64'h0);
    chk("R5 clear line", 64'(irq_o), 64'h0);
    fire_i[3] = 1'b1; step(); fire_i[3] = 1'b0;
    chan_en_i[3] = 1'b0;
    fire_i[3] = 1'b1; step(); fire_i[3] = 1'b0;
    chk("R5 chan disabled fire clears", 64'(status_o), 64'h0);
    chk("R5 chan disabled line", 64'(irq_o), 64'h0);
    chan_en_i[3] = 1'b1;
    fire_i[2] = 1'b1; step(); fire_i[2] = 1'b0;
    glb_en_i = 1'b0;
    fire_i[2] = 1'b1; step(); fire_i[2] = 1'b0;
    chk("R5 global disabled fire clears", 64'(status_o), 64'h0);
    glb_en_i = 1'b1;

    // R11 coincidences
    fire_i[3] = 1'b1; sts_wr_i = 1'b1; sts_wdata_i = 4'b1000;
    step();
    fire_i[3] = 1'b0; sts_wr_i = 1'b0; sts_wdata_i = '0;
    chk("R11 fire beats status write", 64'(status_o), 64'h8);
    fire_i[3] = 1'b1; clear_i[3] = 1'b1;
    step();
    fire_i[3] = 1'b0; clear_i[3] = 1'b0;
    chk("R11 clear beats fire", 64'(status_o), 64'h0);

    // R9 message-enable rise clears status
    fire_i[2] = 1'b1; step(); fire_i[2] = 1'b0;
    chk("R9 status before", 64'(status_o), 64'h4);
    msg_en_i[2] = 1'b1;
    step();
    chk("R9 rise clears", 64'(status_o), 64'h0);
    chk("R5 messaging masks line", 64'(irq_o), 64'h0);
    msg_en_i[2] = 1'b0;
    step();

    // R4 / R10 / R12 messages
    msg_word_i[1*64 +: 64] = {32'hA000_0010, 32'h1111_0001};
    msg_word_i[3*64 +: 64] = {32'hB000_0030, 32'h3333_0003};
    msg_en_i = 4'b1010;
    step();
    fire_i = 4'b1010;
    step();
    fire_i = '0;
    chk("R12 pending not yet requested", 64'(msg_req_o), 64'h0);
    chk("R4 no line on message", 64'(irq_o), 64'h0);
    chk("R4 status untouched", 64'(status_o), 64'h0);
    step();
    chk("R10 first request", 64'(msg_req_o), 64'h1);
    chk("R10 lowest channel addr", 64'(msg_addr_o), 64'hA000_0010);
    chk("R4 data from low word", 64'(msg_data_o), 64'h1111_0001);
    step();
    chk("R4 held without ack", 64'({msg_req_o, msg_addr_o}), {31'h0, 1'b1, 32'hA000_0010});
    msg_ack_i = 1'b1; step(); msg_ack_i = 1'b0;
    chk("R4 drop after ack", 64'(msg_req_o), 64'h0);
    step();
    chk("R10 second request", 64'(msg_req_o), 64'h1);
    chk("R10 second addr", 64'(msg_addr_o), 64'hB000_0030);
    chk("R10 second data", 64'(msg_data_o), 64'h3333_0003);
    msg_ack_i = 1'b1; step(); msg_ack_i = 1'b0;
    step();
    chk("R10 queue empty", 64'(msg_req_o), 64'h0);
    msg_en_i = '0;
    step();

    // R7 / R8 legacy sources
    leg_tmr_i = 1'b1;
    step();
    chk("R8 timer passthrough", 64'(irq_o), 64'h1);
    rtc_i = 1'b1;
    step();
    chk("R8 rtc passthrough", 64'(irq_o), 64'h101);
    legacy_i = 1'b1;
    step();
    chk("R7 leg_en low", 64'(leg_tmr_en_o), 64'h0);
    chk("R7 lines silenced", 64'(irq_o), 64'h0);
    rtc_i = 1'b0;
    step();
    legacy_i = 1'b0;
    step();
    chk("R8 leg_en high on exit", 64'(leg_tmr_en_o), 64'h1);
    chk("R8 rtc recorded low", 64'(irq_o), 64'h1);
    legacy_i = 1'b1;
    step();
    rtc_i = 1'b1;
    step();
    chk("R7 rtc change hidden", 64'(irq_o), 64'h0);
    legacy_i = 1'b0;
    step();
    chk("R8 rtc restored high", 64'(irq_o), 64'h101);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule